// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Controller

This controller sits between a processor load/store port and a slower word-wide main-memory port. Each processor word address is split into a line offset, a set index and a tag. All ways of the indexed set are compared in parallel. A hit completes in the same cycle as the request. A miss stalls the processor while the controller refills the whole line from memory, one word per memory transaction.

Stores go to the cache only and mark the line dirty. When a dirty line is chosen for replacement, all of its words are written back to memory before the refill begins. A free (invalid) way is always used before any valid line is evicted. Among valid ways the victim is chosen by one of two policies, set by a parameter: least recently used, or first filled. With a single way the cache is direct mapped.

The processor holds `req_i`, `we_i`, `addr_i` and `wdata_i` steady until it sees `ready_o` high. The access takes effect on that clock edge.

Top module: `cache_ctrl`

## Requirements
- R1: A word address splits into an offset in bits [OFF_W-1:0], a set index in the next IDX_W bits, and a tag in the remaining upper bits. With the defaults (4 words per line, 4 sets, 12-bit address) these are [1:0], [3:2] and [11:4].
- R2: When a valid way of the indexed set holds a matching tag, `ready_o` rises in the same cycle as `req_i`, `rdata_o` carries the stored word, and no memory transaction occurs. At most one way matches.
- R3: After reset every line is invalid: `ready_o` and `mem_req_o` are low and the first access to any address misses.
- R4: On a miss `ready_o` stays low while the line is refilled. The refill reads every word of the line, in ascending offset order, from the line's base address. Once the refill ends the held request completes as a hit.
- R5: A store that hits updates the cached word and marks the line dirty, with no memory write.
- R6: When the victim line is dirty, all of its words are written to memory at the victim's own address before the first refill read. The written data is the latest stored data.
- R7: A clean victim is replaced without any memory write.
- R8: When any way of the set is invalid, the lowest-numbered invalid way is filled and no valid line is evicted.
- R9: With policy LRU (REPL=0), the victim is the valid way accessed least recently. Every hit counts as an access.
- R10: With policy FIFO (REPL=1), the victim is the way filled earliest. Hits do not change the order.
- R11: With WAYS=1, two addresses with equal index and different tags replace each other.
- R12: A store that misses allocates the line (refill, then merge the stored word) and leaves the line dirty.
- R13: While `mem_req_o` is high and `mem_ack_i` is low, `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Processor access request, held until ready_o |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Store data |
| ready_o | output | 1 | Access completes on this edge |
| rdata_o | output | DATA_W | Load data, valid with ready_o |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | 1 = memory write (write-back), 0 = read (refill) |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Write-back data |
| mem_rdata_i | input | DATA_W | Refill data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Memory transaction done |

## Verification
The hardest case to reach is a dirty line evicted under a specific replacement order. It needs three tags in one set, a store that dirties one line, and a hit that changes recency, all before a third tag forces a choice. The directed sequence uses a store miss to fill the second way, then re-touches the first line so the dirty second line becomes the least recent. A logging memory model records every transaction. From that log the bench confirms that the write-backs come before the refill reads and land at the victim's address. It later reloads the evicted line to confirm that the written-back data survived.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } cache_state_e;

  localparam int REPL_LRU  = 0;
  localparam int REPL_FIFO = 1;
endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic [WAY_W-1:0]           way_o
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec_o[w]) way_o = WAY_W'(w);
  end

  assign hit_o = |hit_vec_o;
endmodule

// File: rtl/cache_repl.sv
module cache_repl
  import cache_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int REPL  = REPL_LRU,
  parameter int WAY_W = 1,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             upd_i,
  input  logic             upd_fill_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [WAY_W-1:0] upd_way_i,
  output logic [WAY_W-1:0] victim_o
);
  if (REPL == REPL_FIFO) begin : g_fifo
    logic [WAY_W-1:0] ptr_q [SETS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
      end else if (upd_i && upd_fill_i) begin
        ptr_q[upd_idx_i] <= (upd_way_i == WAY_W'(WAYS-1)) ? '0 : upd_way_i + WAY_W'(1);
      end
    end

    assign victim_o = ptr_q[idx_i];

    // R10: hits must leave the fill order untouched
    assert_fifo_hit_keeps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i && !upd_fill_i) |=> $stable(ptr_q[0]) && $stable(ptr_q[SETS-1]));
  end else begin : g_lru
    // age 0 = most recent, WAYS-1 = least recent; ages in a set stay distinct
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end else if (upd_i && !upd_fill_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == upd_way_i)
            age_q[upd_idx_i][w] <= '0;
          else if (age_q[upd_idx_i][w] < age_q[upd_idx_i][upd_way_i])
            age_q[upd_idx_i][w] <= age_q[upd_idx_i][w] + WAY_W'(1);
        end
      end
    end

    always_comb begin
      victim_o = '0;
      for (int w = 0; w < WAYS; w++)
        if (age_q[idx_i][w] == WAY_W'(WAYS-1)) victim_o = WAY_W'(w);
    end

    assert_lru_victim_oldest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      age_q[idx_i][victim_o] == WAY_W'(WAYS-1));
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 2,
  parameter int SETS       = 4,
  parameter int LINE_WORDS = 4,
  parameter int REPL       = REPL_LRU
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(LINE_WORDS-1);

  logic [DATA_W-1:0] data_q  [WAYS][SETS][LINE_WORDS];
  logic [TAG_W-1:0]  tag_q   [WAYS][SETS];
  logic              valid_q [WAYS][SETS];
  logic              dirty_q [WAYS][SETS];

  cache_state_e     state_q;
  logic [OFF_W-1:0] cnt_q;
  logic [WAY_W-1:0] victim_q;
  logic [IDX_W-1:0] miss_idx_q;
  logic [TAG_W-1:0] miss_tag_q;

  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign off = addr_i[OFF_W-1:0];
  assign idx = addr_i[OFF_W +: IDX_W];
  assign tag = addr_i[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0]            valid_set;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_tags[w]  = tag_q[w][idx];
      valid_set[w] = valid_q[w][idx];
    end
  end

  logic             hit;
  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way;

  cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .tags_i   (set_tags),
    .valid_i  (valid_set),
    .tag_i    (tag),
    .hit_o    (hit),
    .hit_vec_o(hit_vec),
    .way_o    (hit_way)
  );

  logic             hit_acc, fill_done;
  logic [WAY_W-1:0] repl_victim, victim_sel;

  assign hit_acc   = (state_q == ST_IDLE) && req_i && hit;
  assign fill_done = (state_q == ST_FILL) && mem_ack_i && (cnt_q == LAST);

  cache_repl #(
    .WAYS(WAYS), .SETS(SETS), .REPL(REPL), .WAY_W(WAY_W), .IDX_W(IDX_W)
  ) u_repl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (idx),
    .upd_i     (hit_acc | fill_done),
    .upd_fill_i(fill_done),
    .upd_idx_i (fill_done ? miss_idx_q : idx),
    .upd_way_i (fill_done ? victim_q : hit_way),
    .victim_o  (repl_victim)
  );

  // free ways first, lowest index wins
  always_comb begin
    victim_sel = repl_victim;
    for (int w = WAYS-1; w >= 0; w--)
      if (!valid_set[w]) victim_sel = WAY_W'(w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      victim_q   <= '0;
      miss_idx_q <= '0;
      miss_tag_q <= '0;
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++) begin
          valid_q[w][s] <= 1'b0;
          dirty_q[w][s] <= 1'b0;
        end
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_i && hit) begin
            if (we_i) begin
              data_q[hit_way][idx][off] <= wdata_i;
              dirty_q[hit_way][idx]     <= 1'b1;
            end
          end else if (req_i) begin
            victim_q   <= victim_sel;
            miss_idx_q <= idx;
            miss_tag_q <= tag;
            cnt_q      <= '0;
            state_q    <= (valid_set[victim_sel] && dirty_q[victim_sel][idx]) ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: begin
          if (mem_ack_i) begin
            cnt_q <= cnt_q + OFF_W'(1);
            if (cnt_q == LAST) state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack_i) begin
            data_q[victim_q][miss_idx_q][cnt_q] <= mem_rdata_i;
            cnt_q <= cnt_q + OFF_W'(1);
            if (cnt_q == LAST) begin
              tag_q[victim_q][miss_idx_q]   <= miss_tag_q;
              valid_q[victim_q][miss_idx_q] <= 1'b1;
              dirty_q[victim_q][miss_idx_q] <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = hit_acc;
  assign rdata_o     = hit_acc ? data_q[hit_way][idx][off] : '0;
  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WBACK);
  assign mem_addr_o  = (state_q == ST_WBACK) ? {tag_q[victim_q][miss_idx_q], miss_idx_q, cnt_q}
                                             : {miss_tag_q, miss_idx_q, cnt_q};
  assign mem_wdata_o = (state_q == ST_WBACK) ? data_q[victim_q][miss_idx_q][cnt_q] : '0;

  assert_one_way_hits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  assert_stall_during_mem_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o);

  assert_refill_then_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done |=> (ready_o || !req_i));

  assert_wback_old_tag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o[ADDR_W-1 -: TAG_W] != miss_tag_q));

  assert_free_way_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && req_i && !hit && !(&valid_set)) |=> !valid_q[victim_q][miss_idx_q]);

  assert_mem_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) &&
                                   $stable(mem_addr_o) && $stable(mem_wdata_o)));
endmodule

// File: tb/cache_ctrl_test.sv
module cache_mem_model #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o
);
  logic [DATA_W-1:0] mem [2**ADDR_W];

  initial for (int a = 0; a < 2**ADDR_W; a++) mem[a] = 32'hA500_0000 ^ (a * 7);

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_o <= 1'b0;
    else begin
      ack_o <= req_i && !ack_o;
      if (req_i && we_i && ack_o) mem[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[addr_i];
endmodule

module cache_ctrl_test;
  import cache_pkg::*;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic        req [3], we [3], rdy [3], mreq [3], mwe [3], mack [3];
  logic [11:0] addr [3], maddr [3];
  logic [31:0] wdata [3], rdata [3], mwdata [3], mrdata [3];

  int checks = 0;
  int errors = 0;

  cache_ctrl #(.WAYS(2), .REPL(REPL_LRU)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[0]), .we_i(we[0]), .addr_i(addr[0]),
    .wdata_i(wdata[0]), .ready_o(rdy[0]), .rdata_o(rdata[0]), .mem_req_o(mreq[0]),
    .mem_we_o(mwe[0]), .mem_addr_o(maddr[0]), .mem_wdata_o(mwdata[0]),
    .mem_rdata_i(mrdata[0]), .mem_ack_i(mack[0]));
  cache_ctrl #(.WAYS(2), .REPL(REPL_FIFO)) uut_fifo (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[1]), .we_i(we[1]), .addr_i(addr[1]),
    .wdata_i(wdata[1]), .ready_o(rdy[1]), .rdata_o(rdata[1]), .mem_req_o(mreq[1]),
    .mem_we_o(mwe[1]), .mem_addr_o(maddr[1]), .mem_wdata_o(mwdata[1]),
    .mem_rdata_i(mrdata[1]), .mem_ack_i(mack[1]));
  cache_ctrl #(.WAYS(1), .REPL(REPL_LRU)) uut_dm (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[2]), .we_i(we[2]), .addr_i(addr[2]),
    .wdata_i(wdata[2]), .ready_o(rdy[2]), .rdata_o(rdata[2]), .mem_req_o(mreq[2]),
    .mem_we_o(mwe[2]), .mem_addr_o(maddr[2]), .mem_wdata_o(mwdata[2]),
    .mem_rdata_i(mrdata[2]), .mem_ack_i(mack[2]));

  cache_mem_model m0 (.clk_i(clk), .rst_ni(rst_n), .req_i(mreq[0]), .we_i(mwe[0]), .addr_i(maddr[0]),
                      .wdata_i(mwdata[0]), .rdata_o(mrdata[0]), .ack_o(mack[0]));
  cache_mem_model m1 (.clk_i(clk), .rst_ni(rst_n), .req_i(mreq[1]), .we_i(mwe[1]), .addr_i(maddr[1]),
                      .wdata_i(mwdata[1]), .rdata_o(mrdata[1]), .ack_o(mack[1]));
  cache_mem_model m2 (.clk_i(clk), .rst_ni(rst_n), .req_i(mreq[2]), .we_i(mwe[2]), .addr_i(maddr[2]),
                      .wdata_i(mwdata[2]), .rdata_o(mrdata[2]), .ack_o(mack[2]));

  function automatic logic [31:0] pat(int a);
    return 32'hA500_0000 ^ (a * 7);
  endfunction

  // transaction log per instance
  logic        log_we   [3][256];
  logic [11:0] log_addr [3][256];
  int          log_n    [3];
  int          hold_bad [3];
  logic        prev_wait [3];
  logic [11:0] prev_addr [3];

  initial for (int u = 0; u < 3; u++) begin
    log_n[u] = 0; hold_bad[u] = 0; prev_wait[u] = 0; prev_addr[u] = '0;
    req[u] = 0; we[u] = 0; addr[u] = '0; wdata[u] = '0;
  end

  always @(posedge clk) begin
    for (int u = 0; u < 3; u++) begin
      if (rst_n && mreq[u] && mack[u] && log_n[u] < 256) begin
        log_we[u][log_n[u]]   = mwe[u];
        log_addr[u][log_n[u]] = maddr[u];
        log_n[u]++;
      end
      if (prev_wait[u] && (!mreq[u] || maddr[u] != prev_addr[u])) hold_bad[u]++;
      prev_wait[u] = rst_n && mreq[u] && !mack[u];
      prev_addr[u] = maddr[u];
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(int u, bit w, logic [11:0] a, logic [31:0] d,
                        output logic [31:0] q, output int lat);
    @(negedge clk);
    req[u] = 1; we[u] = w; addr[u] = a; wdata[u] = d; lat = 0;
    #1;
    while (!rdy[u]) begin
      @(negedge clk); #1; lat++;
    end
    q = rdata[u];
    @(posedge clk); #1;
    req[u] = 0; we[u] = 0;
  endtask

  // one access with expected data and memory traffic
  task automatic op(int u, bit w, logic [11:0] a, logic [31:0] d, logic [31:0] exp_q,
                    int exp_rd, int exp_wr, logic [11:0] wb_base, string tag);
    logic [31:0] q;
    int lat, n0, nr, nw;
    n0 = log_n[u];
    access(u, w, a, d, q, lat);
    nr = 0; nw = 0;
    for (int i = n0; i < log_n[u]; i++) if (log_we[u][i]) nw++; else nr++;
    if (!w) check({tag, " data"}, q, exp_q);
    check({tag, " refill reads"}, nr, exp_rd);
    check({tag, " writebacks"}, nw, exp_wr);
    if (exp_rd == 0 && exp_wr == 0) check({tag, " R2 hit latency"}, lat, 0);
    else check({tag, " R4 stalled"}, (lat > 0), 1);
    if (nw == exp_wr && nr == exp_rd) begin
      for (int k = 0; k < exp_wr; k++) begin
        check({tag, " R6 writeback before refill"}, log_we[u][n0+k], 1);
        check({tag, " R6 writeback addr"}, log_addr[u][n0+k], wb_base + 12'(k));
      end
      for (int k = 0; k < exp_rd; k++)
        check({tag, " R4 refill addr order"}, log_addr[u][n0+exp_wr+k], {a[11:2], 2'(k)});
    end
  endtask

  task automatic test_reset;
    for (int u = 0; u < 3; u++) begin
      check("R3 ready low after reset", rdy[u], 0);
      check("R3 mem_req low after reset", mreq[u], 0);
    end
  endtask

  task automatic test_lru;
    op(0, 0, 12'h010, 0, pat('h010), 4, 0, 0, "R3 R4 first miss");
    op(0, 0, 12'h013, 0, pat('h013), 0, 0, 0, "R1 R2 neighbour hit");
    op(0, 1, 12'h011, 32'hDEAD0001, 0, 0, 0, 0, "R5 store hit");
    op(0, 0, 12'h011, 0, 32'hDEAD0001, 0, 0, 0, "R5 store readback");
    op(0, 1, 12'h022, 32'hBEEF0002, 0, 4, 0, 0, "R8 R12 store miss free way");
    op(0, 0, 12'h021, 0, pat('h021), 0, 0, 0, "R12 allocated line");
    op(0, 0, 12'h022, 0, 32'hBEEF0002, 0, 0, 0, "R12 merged word");
    op(0, 0, 12'h010, 0, pat('h010), 0, 0, 0, "R9 touch first line");
    op(0, 0, 12'h030, 0, pat('h030), 4, 4, 12'h020, "R6 R9 dirty lru victim");
    check("R6 memory holds stored word", m0.mem[12'h022], 32'hBEEF0002);
    check("R6 memory holds clean word", m0.mem[12'h021], pat('h021));
    op(0, 0, 12'h011, 0, 32'hDEAD0001, 0, 0, 0, "R9 recent line kept");
    op(0, 0, 12'h040, 0, pat('h040), 4, 0, 0, "R7 R9 clean lru victim");
    op(0, 0, 12'h022, 0, 32'hBEEF0002, 4, 4, 12'h010, "R6 reload written back line");
    check("R6 memory holds first store", m0.mem[12'h011], 32'hDEAD0001);
  endtask

  task automatic test_fifo;
    op(1, 0, 12'h010, 0, pat('h010), 4, 0, 0, "R8 fifo fill way0");
    op(1, 0, 12'h020, 0, pat('h020), 4, 0, 0, "R8 fifo fill way1");
    op(1, 0, 12'h012, 0, pat('h012), 0, 0, 0, "R10 hit oldest");
    op(1, 0, 12'h030, 0, pat('h030), 4, 0, 0, "R10 evict oldest fill");
    op(1, 0, 12'h021, 0, pat('h021), 0, 0, 0, "R10 second fill kept");
    op(1, 0, 12'h010, 0, pat('h010), 4, 0, 0, "R10 oldest was evicted");
  endtask

  task automatic test_direct;
    op(2, 0, 12'h010, 0, pat('h010), 4, 0, 0, "R11 dm fill");
    op(2, 0, 12'h013, 0, pat('h013), 0, 0, 0, "R11 dm hit");
    op(2, 1, 12'h011, 32'h1111_0000, 0, 0, 0, 0, "R11 R5 dm store");
    op(2, 0, 12'h030, 0, pat('h030), 4, 4, 12'h010, "R11 R6 dm conflict");
    op(2, 0, 12'h011, 0, 32'h1111_0000, 4, 0, 0, "R11 R7 dm reload");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    test_reset;
    rst_n = 1;
    repeat (2) @(negedge clk);
    test_lru;
    test_fifo;
    test_direct;
    for (int u = 0; u < 3; u++) check("R13 memory request held until ack", hold_bad[u], 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule